// File: doc/BRIEF.md
# Serial Display Word Streamer

This block drives a serial TFT display controller as an SPI master. Each request arrives on a valid/ready handshake. The block turns it into one or more 16-bit words, and sends each word in its own chip-select frame. A frame is a header byte followed by the word, high byte first. The header byte tells the display whether the word is a register index (RS low) or register data / pixel data (RS high). It also carries a read flag, which this block always leaves clear.

Four request kinds are supported:
- **Register write** sends an index word and then a value word.
- **Cursor set** is two register writes, one to each cursor coordinate register.
- **Memory-write start** selects the display's pixel memory.
- **Pixel** sends one RGB565 word as data.

A host streams a picture by issuing a memory-write start followed by back-to-back pixel requests.

Two parameters set the timing. The serial clock runs at a rate set by `HALF_DIV`, the number of system cycles in each SCLK half period. With the default of 3 at 125 MHz this gives about 20 MHz. A minimum chip-select high time of `GAP_CYCLES` system cycles is enforced between frames; the default of 125 gives 1 µs.

The design is split into two state machines.

The sequencer has three states:
- `SQ_IDLE`: ready is high.
- `SQ_ISSUE`: waiting for the shifter to become idle.
- `SQ_AWAIT`: waiting for the current frame's done pulse.

Its transitions are:
- accept: IDLE→ISSUE
- launch: ISSUE→AWAIT
- next-word: AWAIT→ISSUE
- finish: AWAIT→IDLE

The shifter has five states:
- `SH_IDLE`: CS high, SCLK high.
- `SH_LEAD`: CS low, SCLK high, for one half period.
- `SH_LOW` and `SH_HIGH`: one half period each per bit.
- `SH_GAP`: CS high for the minimum gap.

Its transitions are:
- start: IDLE→LEAD
- first-fall: LEAD→LOW
- rise: LOW→HIGH
- next-bit: HIGH→LOW
- end-frame: HIGH→GAP
- rearm: GAP→IDLE

Top module: `lcd_spi_streamer`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 1, `req_ready` is 1 and `word_done` is 0.
- R2: While `spi_cs_n` is high, `spi_sclk` stays high (SPI mode 3). Every CS-low frame holds exactly 24 SCLK rising edges. `spi_mosi` carries bits most significant first, changes only while SCLK is low, and is sampled on the rising edge.
- R3: The first byte of every frame is 0x70, with bit 1 set when RS=1 and bit 0 (the read flag) always 0. So the byte is 0x70 for an index word and 0x72 for a data word.
- R4: Bits 15..0 of the frame carry the 16-bit word, high byte first, after the header byte.
- R5: A register write (`req_kind`=0) sends two frames: `req_arg_a` with RS=0, then `req_arg_b` with RS=1.
- R6: A cursor set (`req_kind`=1) sends four frames in this order: 0x0020 with RS=0, `req_arg_a` with RS=1, 0x0021 with RS=0, and `req_arg_b` with RS=1.
- R7: A memory-write start (`req_kind`=2) sends one frame, 0x0022 with RS=0.
- R8: A pixel (`req_kind`=3) sends one frame, `req_arg_b` with RS=1.
- R9: Between consecutive frames, `spi_cs_n` stays high for at least `GAP_CYCLES` system cycles.
- R10: Every SCLK half period inside a frame lasts exactly `HALF_DIV` system cycles. This includes the time from CS falling to the first SCLK fall, and the time from the last SCLK rise to CS rising.
- R11: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the last frame of that request ends, and `req_ready` is never high while CS is low. A `req_valid` pulse while ready is low produces no frame.
- R12: `word_done` is a one-cycle pulse in exactly the cycle `spi_cs_n` rises at the end of a frame. There is one pulse per frame and no other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 register write, 1 cursor set, 2 memory-write start, 3 pixel |
| req_arg_a | input | 16 | Register index, or first cursor coordinate |
| req_arg_b | input | 16 | Register value, second cursor coordinate, or pixel word |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select, one frame per word |
| word_done | output | 1 | Pulse as each frame's chip select rises |

## Verification
**Frame timing.** A frame launched from an idle shifter pulls CS low one cycle after acceptance, stays low for 49 × `HALF_DIV` cycles, and ends with `word_done` in the very cycle CS rises. `req_ready` returns the cycle after the last frame's done pulse.

**How the bench samples.** A bench monitor samples every port at the falling system clock edge, so each result is read one half cycle after the edge that produced it. It counts cycles per SCLK level and per CS-high gap, and checks them on each level change against `HALF_DIV` and `GAP_CYCLES`.

**Content checks.** Frame contents are reassembled from the bits at SCLK rising edges. Each request is drained until `req_ready` is high again and all expected frames have arrived. The frames are then compared against a list built arithmetically from the request kind and arguments.

// File: rtl/lcd_spi_pkg.sv
package lcd_spi_pkg;

    localparam int WORD_W     = 16;
    localparam int HDR_W      = 8;
    localparam int FRAME_BITS = HDR_W + WORD_W;
    localparam int WORDS_MAX  = 4;
    localparam int POS_W      = $clog2(WORDS_MAX);

    localparam logic [HDR_W-1:0]  HDR_BASE      = 8'h70;
    localparam logic [WORD_W-1:0] IDX_CURSOR_A  = 16'h0020;
    localparam logic [WORD_W-1:0] IDX_CURSOR_B  = 16'h0021;
    localparam logic [WORD_W-1:0] IDX_MEM_WRITE = 16'h0022;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_CURSOR = 2'd1,
        KIND_MEMWR  = 2'd2,
        KIND_PIXEL  = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic              rs;
        logic [WORD_W-1:0] val;
    } word_t;

    function automatic logic [HDR_W-1:0] make_header(input logic rs, input logic rw);
        return HDR_BASE | {{(HDR_W-2){1'b0}}, rs, rw};
    endfunction

endpackage

// File: rtl/lcd_spi_shifter.sv
module lcd_spi_shifter
    import lcd_spi_pkg::*;
#(
    parameter int HALF_DIV   = 3,
    parameter int GAP_CYCLES = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rs,
    input  logic [WORD_W-1:0] word,
    output logic              idle,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);

    localparam int CNT_MAX = (HALF_DIV > GAP_CYCLES) ? HALF_DIV : GAP_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int BW      = $clog2(FRAME_BITS);
    localparam int GW      = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] HALF_RELOAD = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] GAP_RELOAD  = CW'(GAP_CYCLES - 1);

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LEAD,
        SH_LOW,
        SH_HIGH,
        SH_GAP
    } sh_state_e;

    sh_state_e             state, nxt;
    logic [CW-1:0]         cnt;
    logic [BW-1:0]         bit_idx;
    logic [FRAME_BITS-1:0] shreg;
    logic                  done_q;
    logic                  tick;
    logic                  last_bit;

    assign tick     = (cnt == '0);
    assign last_bit = (bit_idx == BW'(FRAME_BITS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE: if (start) nxt = SH_LEAD;
            SH_LEAD: if (tick)  nxt = SH_LOW;
            SH_LOW:  if (tick)  nxt = SH_HIGH;
            SH_HIGH: if (tick)  nxt = last_bit ? SH_GAP : SH_LOW;
            SH_GAP:  if (tick)  nxt = SH_IDLE;
            default:            nxt = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            done_q  <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (state == SH_HIGH) && tick && last_bit;
            if (state != nxt) begin
                cnt <= (nxt == SH_GAP) ? GAP_RELOAD : HALF_RELOAD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (state == SH_IDLE && start) begin
                shreg   <= {make_header(rs, 1'b0), word};
                bit_idx <= '0;
            end else if (state == SH_HIGH && tick && !last_bit) begin
                shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        idle = (state == SH_IDLE);
        sclk = (state != SH_LOW);
        cs_n = (state == SH_IDLE) || (state == SH_GAP);
        mosi = shreg[FRAME_BITS-1];
        done = done_q;
    end

    logic [GW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= GW'(GAP_CYCLES);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < GW'(GAP_CYCLES)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R12
    done_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    // R2
    cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R9
    gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GW'(GAP_CYCLES)));

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(mosi));

endmodule

// File: rtl/lcd_spi_seq.sv
module lcd_spi_seq
    import lcd_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] arg_a,
    input  logic [WORD_W-1:0] arg_b,
    output logic              req_ready,
    input  logic              shf_idle,
    input  logic              shf_done,
    output logic              shf_start,
    output logic              shf_rs,
    output logic [WORD_W-1:0] shf_word
);

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_AWAIT
    } sq_state_e;

    sq_state_e        state, nxt;
    word_t            plan_q [WORDS_MAX];
    word_t            plan_d [WORDS_MAX];
    logic [POS_W-1:0] pos_q, last_q, last_d;
    req_kind_e        kind;

    assign kind = req_kind_e'(req_kind);

    always_comb begin
        for (int k = 0; k < WORDS_MAX; k++) begin
            plan_d[k] = '0;
        end
        last_d = '0;
        unique case (kind)
            KIND_REG: begin
                plan_d[0].val = arg_a;
                plan_d[1].rs  = 1'b1;
                plan_d[1].val = arg_b;
                last_d        = POS_W'(1);
            end
            KIND_CURSOR: begin
                plan_d[0].val = IDX_CURSOR_A;
                plan_d[1].rs  = 1'b1;
                plan_d[1].val = arg_a;
                plan_d[2].val = IDX_CURSOR_B;
                plan_d[3].rs  = 1'b1;
                plan_d[3].val = arg_b;
                last_d        = POS_W'(3);
            end
            KIND_MEMWR: begin
                plan_d[0].val = IDX_MEM_WRITE;
            end
            KIND_PIXEL: begin
                plan_d[0].rs  = 1'b1;
                plan_d[0].val = arg_b;
            end
            default: begin
                last_d = '0;
            end
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:  if (req_valid) nxt = SQ_ISSUE;
            SQ_ISSUE: if (shf_idle)  nxt = SQ_AWAIT;
            SQ_AWAIT: if (shf_done)  nxt = (pos_q == last_q) ? SQ_IDLE : SQ_ISSUE;
            default:                 nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            pos_q  <= '0;
            last_q <= '0;
            for (int k = 0; k < WORDS_MAX; k++) begin
                plan_q[k] <= '0;
            end
        end else begin
            state <= nxt;
            if (state == SQ_IDLE && req_valid) begin
                plan_q <= plan_d;
                last_q <= last_d;
                pos_q  <= '0;
            end else if (state == SQ_AWAIT && shf_done && pos_q != last_q) begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_ready = (state == SQ_IDLE);
        shf_start = (state == SQ_ISSUE) && shf_idle;
        shf_rs    = plan_q[pos_q].rs;
        shf_word  = plan_q[pos_q].val;
    end

    // R12
    done_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shf_done |-> (state == SQ_AWAIT));

    // R11
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shf_start |=> !shf_idle);

endmodule

// File: rtl/lcd_spi_streamer.sv
module lcd_spi_streamer
    import lcd_spi_pkg::*;
#(
    parameter int HALF_DIV   = 3,
    parameter int GAP_CYCLES = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_arg_a,
    input  logic [15:0] req_arg_b,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    output logic        word_done
);

    logic              shf_idle;
    logic              shf_done;
    logic              shf_start;
    logic              shf_rs;
    logic [WORD_W-1:0] shf_word;

    lcd_spi_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .arg_a     (req_arg_a),
        .arg_b     (req_arg_b),
        .req_ready (req_ready),
        .shf_idle  (shf_idle),
        .shf_done  (shf_done),
        .shf_start (shf_start),
        .shf_rs    (shf_rs),
        .shf_word  (shf_word)
    );

    lcd_spi_shifter #(
        .HALF_DIV   (HALF_DIV),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .start (shf_start),
        .rs    (shf_rs),
        .word  (shf_word),
        .idle  (shf_idle),
        .done  (shf_done),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );

    assign word_done = shf_done;

    // R11
    shifting_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !req_ready);

endmodule

// File: tb/lcd_spi_streamer_tb.sv
module lcd_spi_streamer_tb;

    localparam int HALF = 2;
    localparam int GAP  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_arg_a = '0;
    logic [15:0] req_arg_b = '0;
    logic        spi_sclk, spi_mosi, spi_cs_n, word_done;

    always #4 clk = ~clk;

    lcd_spi_streamer #(.HALF_DIV(HALF), .GAP_CYCLES(GAP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_arg_a (req_arg_a),
        .req_arg_b (req_arg_b),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_cs_n  (spi_cs_n),
        .word_done (word_done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [23:0] exp_q [0:511];
    logic [23:0] got_q [0:511];
    int exp_n = 0;
    int got_n = 0;
    int cmp_n = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor: reassemble frames and time SCLK/CS levels at the falling clock edge
    logic        prev_cs = 1'b1, prev_sclk = 1'b1, prev_mosi = 1'b0;
    logic [23:0] mon_sh = '0;
    int          run = 0, bits = 0, gap_run = 0, frames_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !spi_cs_n) begin
                if (frames_seen > 0) chk(gap_run >= GAP, "R9 CS-high gap", gap_run, GAP);
                bits = 0;
                run = 1;
                mon_sh = '0;
            end else if (!spi_cs_n) begin
                if (spi_sclk != prev_sclk) begin
                    chk(run == HALF, "R10 SCLK half period", run, HALF);
                    run = 1;
                    if (spi_sclk) begin
                        mon_sh = {mon_sh[22:0], spi_mosi};
                        bits++;
                    end
                end else begin
                    run++;
                    if (spi_sclk && prev_sclk && spi_mosi != prev_mosi)
                        chk(1'b0, "R2 MOSI changed while SCLK high", int'(spi_mosi), int'(prev_mosi));
                end
            end else if (!prev_cs && spi_cs_n) begin
                chk(run == HALF, "R10 last rise to CS rise", run, HALF);
                chk(bits == 24, "R2 rising edges per frame", bits, 24);
                chk(word_done == 1'b1, "R12 done at CS rise", int'(word_done), 1);
                got_q[got_n] = mon_sh;
                got_n++;
                gap_run = 1;
                frames_seen++;
            end else begin
                gap_run++;
                if (word_done) chk(1'b0, "R12 stray done pulse", 1, 0);
            end
            if (spi_cs_n && !spi_sclk) chk(1'b0, "R2 SCLK low while idle", 0, 1);
            if (!spi_cs_n && req_ready) chk(1'b0, "R11 ready high during frame", 1, 0);
            if (!spi_cs_n && word_done) chk(1'b0, "R12 done while CS low", 1, 0);
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog expired", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic push_exp(input logic rs, input logic [15:0] v);
        exp_q[exp_n] = {8'h70 | (rs ? 8'h02 : 8'h00), v};
        exp_n++;
    endtask

    task automatic expect_req(input logic [1:0] k, input logic [15:0] a, input logic [15:0] b);
        case (k)
            2'd0: begin push_exp(1'b0, a); push_exp(1'b1, b); end
            2'd1: begin
                push_exp(1'b0, 16'h0020); push_exp(1'b1, a);
                push_exp(1'b0, 16'h0021); push_exp(1'b1, b);
            end
            2'd2: push_exp(1'b0, 16'h0022);
            default: push_exp(1'b1, b);
        endcase
    endtask

    task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_arg_a = a;
        req_arg_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 ready low after accept", int'(req_ready), 0);
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while (!(got_n >= exp_n && req_ready) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (GAP + 3) @(negedge clk);
        chk(got_n == exp_n, {tag, " frame count"}, got_n, exp_n);
        for (int i = cmp_n; i < exp_n; i++) begin
            chk(got_q[i] == exp_q[i], {tag, " frame content (R3 R4)"}, int'(got_q[i]), int'(exp_q[i]));
        end
        cmp_n = exp_n;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 CS in reset", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 CS after reset", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b1, "R1 SCLK after reset", int'(spi_sclk), 1);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(word_done == 1'b0, "R1 done after reset", int'(word_done), 0);

        // R5: register writes with walking-one index and inverted value
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            a = 16'h1 << i;
            expect_req(2'd0, a, ~a);
            issue(2'd0, a, ~a);
            drain("R5 register write");
        end

        // R6: cursor sets across a 320x240 range
        for (int i = 0; i < 6; i++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'(i * 53);
            y = 16'(239 - i * 41);
            expect_req(2'd1, x, y);
            issue(2'd1, x, y);
            drain("R6 cursor set");
        end

        // R7 then R8: memory-write start followed by a pixel stream
        expect_req(2'd2, 16'hdead, 16'hbeef);
        issue(2'd2, 16'hdead, 16'hbeef);
        drain("R7 memory-write start");
        for (int i = 0; i < 48; i++) begin
            logic [15:0] p;
            p = 16'(i * 16'h0841) ^ 16'(i << 11);
            if (i == 46) p = 16'hffff;
            if (i == 47) p = 16'h0000;
            expect_req(2'd3, 16'h5a5a, p);
            issue(2'd3, 16'h5a5a, p);
        end
        drain("R8 pixel stream");

        // R11: a valid pulse while busy is not taken
        expect_req(2'd0, 16'h0007, 16'h0133);
        issue(2'd0, 16'h0007, 16'h0133);
        req_valid = 1'b1;
        req_kind  = 2'd3;
        req_arg_b = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        drain("R11 ignored request");

        summary_and_end();
    end

endmodule